// File: doc/BRIEF.md
# Banked Register File Address Unit

This unit sits between the instruction decoder of a small 8-bit controller core and its data register array. Each cycle it turns the 7-bit file offset taken from the current instruction into a 9-bit physical register index. The bank comes from one of two places. A direct access takes its bank from two bank-select bits. An access to offset zero is an indirect access. It takes its bank from a separate indirect-bank bit, and the 8-bit pointer register supplies the rest of the index.

Some locations are folded onto a single storage location whatever the bank. These are the 16-location common window at the top of every bank and four core registers at fixed low offsets: program-counter low byte, status, pointer and program-counter latch. For these the unit reports bank zero and raises a one-hot select, so downstream logic can route the access to one place.

The unit also holds the pointer register and the three bank bits of the status register. Any write that resolves to those registers updates them.

Top module: `regfile_addr_unit`

## Requirements
- R1: For a direct access (offset not 0) whose offset lies in 0x05–0x6F and is not 0x0A, the physical index is {bank_sel[1:0], file_addr}.
- R2: An access with file_addr == 0 is indirect. Its physical index is {bank_sel[2], fsr_val[7:0]}.
- R3: When the resolved offset (low 7 bits of the direct or indirect index) is 0x70–0x7F, common_hit is 1 and phys_addr is the offset with the two bank bits forced to 0.
- R4: A resolved offset of 0x02, 0x03, 0x04 or 0x0A sets exactly one shared_sel bit: bit0, bit1, bit2 or bit3 respectively. phys_addr is then the offset in bank 0, for every bank.
- R5: An indirect access whose pointer gives offset 0 (fsr_val[6:0] == 0) raises null_acc, so that downstream reads return 0. It drops wr_out, and neither fsr_val nor bank_sel changes.
- R6: A write (acc_en=1, wr_en=1) that resolves to shared_sel bit2, directly or indirectly, loads fsr_val from wr_data on the next clock. fsr_val holds in every other cycle.
- R7: A write that resolves to shared_sel bit1 loads bank_sel from wr_data[7:5], in the order {indirect bank, bank bit1, bank bit0}. wr_data[4:0] has no effect on the unit.
- R8: After reset, fsr_val and bank_sel are 0, so accesses start in bank 0.
- R9: wr_out equals acc_en & wr_en & ~null_acc. With acc_en low, shared_sel, common_hit and sfr_zone are 0 and no register is loaded.
- R10: sfr_zone is 1 when the resolved offset is below 0x20. Such offsets, other than the four shared ones, stay banked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_en | input | 1 | A data-memory access is taking place this cycle |
| wr_en | input | 1 | The access is a write |
| file_addr | input | 7 | File offset from the instruction |
| wr_data | input | 8 | Write data of the access |
| phys_addr | output | 9 | Resolved physical register index |
| shared_sel | output | 4 | One-hot select: PCL, STATUS, pointer, PC latch |
| common_hit | output | 1 | Access falls in the bank-shared window |
| sfr_zone | output | 1 | Resolved offset is in the special-register region |
| null_acc | output | 1 | Indirect access through a pointer to offset 0 |
| wr_out | output | 1 | Write strobe forwarded to the register array |
| fsr_val | output | 8 | Current pointer register value |
| bank_sel | output | 3 | Current {indirect bank, bank bit1, bank bit0} |

## Verification
Some properties are checked on every cycle. The shared selects are never more than one-hot. A null indirect access never produces a write. A general-purpose direct access always carries the current bank bits. Shared locations always resolve to bank 0. The pointer and bank bits load only when written and otherwise hold.

Other behaviour shows only in the bench's directed scenarios. These cover exact index values in each of the four banks, the indirect index with both indirect-bank settings, and the common window reached through the pointer. They also cover writing the pointer through itself, the masking of the low status bits, and the reset state.

// File: rtl/rfau_pkg.sv
package rfau_pkg;

  // Indices into the one-hot shared-register select.
  typedef enum logic [1:0] {
    SH_PCL    = 2'd0,
    SH_STATUS = 2'd1,
    SH_PTR    = 2'd2,
    SH_PCLATH = 2'd3
  } shared_idx_e;

  localparam int unsigned N_SHARED = 4;
  localparam int unsigned SFR_SPAN = 32;
  localparam int unsigned COMMON_BASE = 112;

  // In-bank offset of each bank-shared core register.
  function automatic logic [6:0] shared_offset(input int unsigned idx);
    case (idx)
      0:       shared_offset = 7'h02;
      1:       shared_offset = 7'h03;
      2:       shared_offset = 7'h04;
      default: shared_offset = 7'h0A;
    endcase
  endfunction

endpackage

// File: rtl/rfau_bank_regs.sv
module rfau_bank_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned SB_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ptr,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [SB_W-1:0]   sb_q
);

  // Reset synchronizer: asserts at once, releases on the clock.
  logic rst_meta;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  // Next-state logic.
  logic             ptr_en;
  logic             sb_en;
  logic [PTR_W-1:0] ptr_d;
  logic [SB_W-1:0]  sb_d;

  always_comb begin
    ptr_en = wr_ptr;
    sb_en  = wr_stat;
    ptr_d  = wr_data[PTR_W-1:0];
    sb_d   = wr_data[DATA_W-1 -: SB_W];
  end

  // State registers with explicit clock enables.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sb_q <= '0;
    end else if (sb_en) begin
      sb_q <= sb_d;
    end
  end

  p_ptr_load_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_ptr |=> (ptr_q == $past(wr_data[PTR_W-1:0])));
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_ptr |=> $stable(ptr_q));
  p_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stat |=> (sb_q == $past(wr_data[DATA_W-1 -: SB_W])));
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_stat |=> $stable(sb_q));

endmodule

// File: rtl/rfau_addr_map.sv
module rfau_addr_map #(
  parameter int unsigned OFS_W  = 7,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned SB_W   = 3,
  parameter int unsigned PHYS_W = 9
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic [SB_W-1:0]   sb_q,
  output logic              indirect,
  output logic [PHYS_W-1:0] raw_addr
);

  localparam int unsigned IRP_W = PHYS_W - PTR_W;

  logic [PHYS_W-1:0] dir_addr;
  logic [PHYS_W-1:0] ind_addr;

  always_comb begin
    indirect = (ofs == '0);
    dir_addr = {sb_q[BANK_W-1:0], ofs};
    ind_addr = {sb_q[SB_W-1 -: IRP_W], ptr_q};
    raw_addr = indirect ? ind_addr : dir_addr;
  end

endmodule

// File: rtl/rfau_decode.sv
module rfau_decode
  import rfau_pkg::*;
#(
  parameter int unsigned OFS_W  = 7,
  parameter int unsigned PHYS_W = 9
) (
  input  logic                acc_en,
  input  logic                indirect,
  input  logic [PHYS_W-1:0]   raw_addr,
  output logic [PHYS_W-1:0]   phys_addr,
  output logic [N_SHARED-1:0] shared_sel,
  output logic                common_hit,
  output logic                sfr_zone,
  output logic                null_ptr
);

  logic [OFS_W-1:0]    low;
  logic [N_SHARED-1:0] sh_match;

  assign low = raw_addr[OFS_W-1:0];

  for (genvar i = 0; i < N_SHARED; i++) begin : g_shared
    assign sh_match[i] = (low == OFS_W'(shared_offset(i)));
  end

  logic in_common;
  logic folded;

  always_comb begin
    in_common  = (low >= OFS_W'(COMMON_BASE));
    null_ptr   = indirect && (low == '0);
    folded     = in_common || (|sh_match);
    shared_sel = acc_en ? sh_match : '0;
    common_hit = acc_en && in_common;
    sfr_zone   = acc_en && (low < OFS_W'(SFR_SPAN));
    if (null_ptr) begin
      phys_addr = '0;
    end else if (folded) begin
      phys_addr = {{(PHYS_W-OFS_W){1'b0}}, low};
    end else begin
      phys_addr = raw_addr;
    end
  end

  p_shared_onehot_r4: assert final ($onehot0(shared_sel));
  p_common_vs_shared_r3: assert final (!(common_hit && (|shared_sel)));

endmodule

// File: rtl/regfile_addr_unit.sv
module regfile_addr_unit
  import rfau_pkg::*;
#(
  parameter int unsigned OFS_W  = 7,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_en,
  input  logic                       wr_en,
  input  logic [OFS_W-1:0]           file_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [OFS_W+BANK_W-1:0]    phys_addr,
  output logic [N_SHARED-1:0]        shared_sel,
  output logic                       common_hit,
  output logic                       sfr_zone,
  output logic                       null_acc,
  output logic                       wr_out,
  output logic [OFS_W:0]             fsr_val,
  output logic [2*BANK_W-2:0]        bank_sel
);

  localparam int unsigned PHYS_W = OFS_W + BANK_W;
  localparam int unsigned PTR_W  = OFS_W + 1;
  localparam int unsigned SB_W   = 2 * BANK_W - 1;

  logic              indirect;
  logic [PHYS_W-1:0] raw_addr;
  logic              wr_ptr;
  logic              wr_stat;

  rfau_addr_map #(
    .OFS_W (OFS_W),
    .BANK_W(BANK_W),
    .PTR_W (PTR_W),
    .SB_W  (SB_W),
    .PHYS_W(PHYS_W)
  ) u_map (
    .ofs     (file_addr),
    .ptr_q   (fsr_val),
    .sb_q    (bank_sel),
    .indirect(indirect),
    .raw_addr(raw_addr)
  );

  rfau_decode #(
    .OFS_W (OFS_W),
    .PHYS_W(PHYS_W)
  ) u_dec (
    .acc_en    (acc_en),
    .indirect  (indirect),
    .raw_addr  (raw_addr),
    .phys_addr (phys_addr),
    .shared_sel(shared_sel),
    .common_hit(common_hit),
    .sfr_zone  (sfr_zone),
    .null_ptr  (null_acc)
  );

  always_comb begin
    wr_out  = acc_en && wr_en && !null_acc;
    wr_ptr  = wr_out && shared_sel[SH_PTR];
    wr_stat = wr_out && shared_sel[SH_STATUS];
  end

  rfau_bank_regs #(
    .DATA_W(DATA_W),
    .PTR_W (PTR_W),
    .SB_W  (SB_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ptr (wr_ptr),
    .wr_stat(wr_stat),
    .wr_data(wr_data),
    .ptr_q  (fsr_val),
    .sb_q   (bank_sel)
  );

  p_general_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && file_addr >= OFS_W'(32) && file_addr < OFS_W'(COMMON_BASE))
      |-> (phys_addr[PHYS_W-1 -: BANK_W] == bank_sel[BANK_W-1:0]));
  p_folded_bank0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (common_hit || (|shared_sel)) |-> (phys_addr[PHYS_W-1 -: BANK_W] == '0));
  p_null_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    null_acc |-> !wr_out);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (shared_sel == '0 && !wr_out && !common_hit));

endmodule

// File: tb/sim_regfile_addr_unit.sv
module sim_regfile_addr_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_en;
  logic       wr_en;
  logic [6:0] file_addr;
  logic [7:0] wr_data;
  logic [8:0] phys_addr;
  logic [3:0] shared_sel;
  logic       common_hit;
  logic       sfr_zone;
  logic       null_acc;
  logic       wr_out;
  logic [7:0] fsr_val;
  logic [2:0] bank_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
    .file_addr(file_addr), .wr_data(wr_data), .phys_addr(phys_addr),
    .shared_sel(shared_sel), .common_hit(common_hit), .sfr_zone(sfr_zone),
    .null_acc(null_acc), .wr_out(wr_out), .fsr_val(fsr_val), .bank_sel(bank_sel)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  // Drive a read access at the falling edge, sample shortly after.
  task automatic look(input logic [6:0] ofs);
    @(negedge clk);
    acc_en = 1'b1; wr_en = 1'b0; file_addr = ofs; wr_data = 8'h00;
    #1;
  endtask

  task automatic do_write(input logic [6:0] ofs, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; wr_en = 1'b1; file_addr = ofs; wr_data = d;
    @(negedge clk);
    acc_en = 1'b0; wr_en = 1'b0;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_en = 1'b0; wr_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    idle();
    check("R8 pointer reset", fsr_val, 0);
    check("R8 bank reset", bank_sel, 0);
    check("R9 idle shared_sel", shared_sel, 0);
    check("R9 idle wr_out", wr_out, 0);
  endtask

  task automatic t_direct();
    for (int b = 0; b < 4; b++) begin
      do_write(7'h03, 8'(b << 5));
      look(7'h35);
      check("R1 general direct", phys_addr, b * 128 + 'h35);
      check("R1 no common", common_hit, 0);
      look(7'h05);
      check("R10 banked sfr index", phys_addr, b * 128 + 5);
      check("R10 sfr_zone", sfr_zone, 1);
      look(7'h20);
      check("R10 gp not sfr", sfr_zone, 0);
    end
  endtask

  task automatic t_common();
    for (int b = 0; b < 4; b++) begin
      do_write(7'h03, 8'(b << 5));
      look(7'h7A);
      check("R3 common index", phys_addr, 'h7A);
      check("R3 common_hit", common_hit, 1);
    end
  endtask

  task automatic t_shared();
    logic [6:0] ofs [4] = '{7'h02, 7'h03, 7'h04, 7'h0A};
    for (int b = 0; b < 4; b++) begin
      do_write(7'h03, 8'(b << 5));
      for (int i = 0; i < 4; i++) begin
        look(ofs[i]);
        check("R4 shared index", phys_addr, ofs[i]);
        check("R4 shared onehot", shared_sel, 1 << i);
      end
    end
    do_write(7'h03, 8'h00);
  endtask

  task automatic t_indirect();
    do_write(7'h04, 8'hA5);
    check("R6 pointer direct write", fsr_val, 'hA5);
    do_write(7'h03, 8'h80);
    look(7'h00);
    check("R2 indirect irp=1", phys_addr, 'h1A5);
    do_write(7'h03, 8'h60);
    look(7'h00);
    check("R2 indirect irp=0", phys_addr, 'h0A5);
    do_write(7'h04, 8'hF3);
    do_write(7'h03, 8'h80);
    look(7'h00);
    check("R3 indirect common index", phys_addr, 'h073);
    check("R3 indirect common_hit", common_hit, 1);
  endtask

  task automatic t_null();
    do_write(7'h04, 8'h80);
    @(negedge clk);
    acc_en = 1'b1; wr_en = 1'b1; file_addr = 7'h00; wr_data = 8'h5A;
    #1;
    check("R5 null flag", null_acc, 1);
    check("R5 no write", wr_out, 0);
    idle();
    check("R5 pointer untouched", fsr_val, 'h80);
    check("R5 bank untouched", bank_sel, 'h4);
  endtask

  task automatic t_ptr_self();
    do_write(7'h04, 8'h84);
    look(7'h00);
    check("R4 pointer via pointer index", phys_addr, 'h004);
    check("R4 pointer via pointer sel", shared_sel, 4);
    do_write(7'h00, 8'h3C);
    check("R6 pointer via indirect", fsr_val, 'h3C);
  endtask

  task automatic t_status_mask();
    do_write(7'h03, 8'hFF);
    check("R7 all bank bits", bank_sel, 7);
    do_write(7'h03, 8'h1F);
    check("R7 low bits ignored", bank_sel, 0);
  endtask

  task automatic t_ignore();
    do_write(7'h04, 8'h11);
    @(negedge clk);
    acc_en = 1'b0; wr_en = 1'b1; file_addr = 7'h04; wr_data = 8'h77;
    #1;
    check("R9 disabled wr_out", wr_out, 0);
    check("R9 disabled shared_sel", shared_sel, 0);
    check("R9 disabled common", common_hit, 0);
    idle();
    check("R9 pointer not loaded", fsr_val, 'h11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; wr_en = 1'b0; file_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direct();
    t_common();
    t_shared();
    t_indirect();
    t_null();
    t_ptr_self();
    t_status_mask();
    t_ignore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule